// File: doc/BRIEF.md
# Packed Decimal Add/Subtract Engine

This block adds or subtracts two signed packed decimal numbers of variable length. Each number sits in its own local byte buffer of up to 16 bytes, and each byte holds two BCD digits. The sign code is in the low nibble of the least significant byte. The block has four steps. It validates both operands one byte per cycle. It combines them one byte per cycle, with a carry or a borrow running upward from the least significant byte. When an effective subtraction ends with a borrow, it makes a second tens-complement pass. Last, it writes a preferred sign code into the result, which replaces the first operand in place.

A host loads the two buffers through a byte write port. It gives the two lengths, an add/subtract select and a code-mode bit, and then pulses `start`. The engine reports completion with a one-cycle `done` pulse. At that point two flags hold the outcome: one for a data exception and one for a decimal overflow. The host reads the result back through a byte read port on the first operand buffer.

Top module: `pdec_addsub_top`

## Requirements
- R1: After reset, `done`, `busy`, `data_exc` and `dec_ovf` are all low.
- R2: Byte address 0 is the least significant byte, and its low nibble is the sign. Every other nibble is a BCD digit, with the high nibble the more significant. A length input carries the byte count minus one, so 0 to 15 stands for 1 to 16 bytes. The result occupies first-operand bytes 0 to len-1.
- R3: Sign codes 4'hB and 4'hD are read as minus. Codes 4'hA, 4'hC, 4'hE and 4'hF are read as plus.
- R4: The written sign is 4'hC for a plus result and 4'hD for a minus result, whichever value `alt_code_mode` has.
- R5: With `sub_req`=0 the result is op1+op2, and with `sub_req`=1 it is op1-op2. The shorter operand is treated as if extended with leading zero digits.
- R6: A digit nibble above 9, or a sign nibble of 0 to 9, in either operand sets `data_exc` and ends the operation. The first operand buffer then stays unchanged and `dec_ovf` stays low.
- R7: When the exact result has a nonzero digit beyond the 2*len1-1 digits of the first field, `dec_ovf` is set. The low-order digits are still written, and the sign is that of the exact result.
- R8: An exact result of zero is always written with the plus code 4'hC.
- R9: `done` is high for exactly one cycle, and `busy` is low while `done` is high. Both flags hold until the next accepted start.
- R10: A `start` pulse while `busy` is high is ignored and does not change the running operation.
- R11: When the subtrahend magnitude exceeds the minuend magnitude, the result is the true magnitude of the difference, with the sign opposite to the first operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one byte into an operand buffer |
| ld_sel | input | 1 | Buffer select: 0 first operand, 1 second operand |
| ld_addr | input | 4 | Byte address for the load |
| ld_data | input | 8 | Byte to load |
| len_a_m1 | input | 4 | First operand length minus one |
| len_b_m1 | input | 4 | Second operand length minus one |
| sub_req | input | 1 | 1 subtracts the second operand |
| alt_code_mode | input | 1 | Code-mode select; does not change the sign codes written |
| start | input | 1 | Begin an operation when idle |
| rd_addr | input | 4 | Byte address into the first operand buffer |
| rd_data | output | 8 | Byte read from the first operand buffer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| data_exc | output | 1 | Invalid digit or sign found |
| dec_ovf | output | 1 | Result exceeds the first field |

## Verification
The add path is driven with same-sign pairs, both positive and both negative. This separates a correct carry chain from a carry that is dropped at the byte seam or at the sign nibble. Mixed-sign pairs are run with the minuend larger, smaller and equal. They tell the single-pass case apart from the complement pass, and show the zero-sign rule. Operands of unequal lengths, in both orders, show whether the zero padding is right and whether overflow is caught from a carry out or from a longer second operand. Random fields with every accepted sign code, and a few corrupt nibbles, cover sign decode and the exception path.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SUM,
    ST_RECOMP,
    ST_SIGN
  } eng_state_t;

  localparam logic [3:0] SGN_PLUS  = 4'hC;
  localparam logic [3:0] SGN_MINUS = 4'hD;

  function automatic logic nib_is_digit(input logic [3:0] n);
    return n <= 4'd9;
  endfunction

  function automatic logic code_is_minus(input logic [3:0] n);
    return (n == 4'hB) || (n == 4'hD);
  endfunction

  // lowest byte: high nibble digit, low nibble sign code
  function automatic logic byte_valid(input logic [7:0] b, input logic lowest);
    if (lowest) return nib_is_digit(b[7:4]) && !nib_is_digit(b[3:0]);
    return nib_is_digit(b[7:4]) && nib_is_digit(b[3:0]);
  endfunction

  // one decimal digit step, result {carry_or_borrow, digit}
  function automatic logic [4:0] digit_step(input logic [3:0] a, input logic [3:0] b,
                                            input logic cin, input logic subtract);
    logic [4:0] t;
    logic [4:0] u;
    if (!subtract) begin
      t = {1'b0, a} + {1'b0, b} + {4'b0, cin};
      u = t - 5'd10;
      if (t > 5'd9) return {1'b1, u[3:0]};
      return {1'b0, t[3:0]};
    end
    t = {1'b0, a} - {1'b0, b} - {4'b0, cin};
    u = t + 5'd10;
    if (t[4]) return {1'b1, u[3:0]};
    return {1'b0, t[3:0]};
  endfunction

endpackage

// File: rtl/pdec_opbufs.sv
module pdec_opbufs #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic          ld_sel,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic [AW-1:0] eng_idx,
  output logic [7:0]    a_byte,
  output logic [7:0]    b_byte,
  input  logic          wr_en,
  input  logic [7:0]    wr_byte,
  input  logic          sign_we,
  input  logic [3:0]    sign_code
);
  logic [7:0] buf_a [DEPTH];
  logic [7:0] buf_b [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_en && !ld_sel) buf_a[ld_addr] <= ld_data;
    if (ld_en && ld_sel)  buf_b[ld_addr] <= ld_data;
    if (wr_en)            buf_a[eng_idx] <= wr_byte;
    if (sign_we)          buf_a[0][3:0]  <= sign_code;
  end

  assign rd_data = buf_a[rd_addr];
  assign a_byte  = buf_a[eng_idx];
  assign b_byte  = buf_b[eng_idx];

  // R4
  sign_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sign_we && !ld_en |=> (buf_a[0][3:0] == 4'hC) || (buf_a[0][3:0] == 4'hD));

endmodule

// File: rtl/pdec_byte_alu.sv
module pdec_byte_alu
  import pdec_pkg::*;
(
  input  logic [7:0] x_byte,
  input  logic [7:0] y_byte,
  input  logic       lowest,
  input  logic       cin,
  input  logic       subtract,
  output logic [7:0] r_byte,
  output logic       cout,
  output logic       r_nonzero
);
  logic [4:0] lo_res;
  logic [4:0] hi_res;
  logic       mid_c;

  always_comb begin
    lo_res = digit_step(x_byte[3:0], y_byte[3:0], cin, subtract);
    mid_c  = lowest ? cin : lo_res[4];
    hi_res = digit_step(x_byte[7:4], y_byte[7:4], mid_c, subtract);
    r_byte[7:4] = hi_res[3:0];
    r_byte[3:0] = lowest ? x_byte[3:0] : lo_res[3:0];
    cout        = hi_res[4];
    r_nonzero   = (hi_res[3:0] != 4'd0) || (!lowest && (lo_res[3:0] != 4'd0));
  end

endmodule

// File: rtl/pdec_ctrl.sv
module pdec_ctrl
  import pdec_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] len_a_m1,
  input  logic [AW-1:0] len_b_m1,
  input  logic          sub_req,
  input  logic          alt_code_mode,
  input  logic [7:0]    a_byte,
  input  logic [7:0]    b_byte,
  output logic [7:0]    alu_x,
  output logic [7:0]    alu_y,
  output logic          alu_lowest,
  output logic          alu_cin,
  output logic          alu_sub,
  input  logic [7:0]    alu_r,
  input  logic          alu_cout,
  input  logic          alu_nz,
  output logic [AW-1:0] eng_idx,
  output logic          wr_en,
  output logic [7:0]    wr_byte,
  output logic          sign_we,
  output logic [3:0]    sign_code,
  output logic          busy,
  output logic          done,
  output logic          data_exc,
  output logic          dec_ovf
);
  eng_state_t    st;
  logic [AW-1:0] idx, last_idx, lena_q, lenb_q;
  logic          sub_q, mode_q, neg_a, neg_b, flip;
  logic          carry, hi_nz, any_nz;

  // named internal events
  logic in_a, in_b, lowest, at_last, beyond, eff_sub, bad_byte, result_nz, neg_res;

  always_comb begin
    in_a      = idx <= lena_q;
    in_b      = idx <= lenb_q;
    lowest    = idx == '0;
    at_last   = idx == last_idx;
    beyond    = !in_a;
    eff_sub   = neg_a ^ neg_b ^ sub_q;
    bad_byte  = (in_a && !byte_valid(a_byte, lowest)) ||
                (in_b && !byte_valid(b_byte, lowest));
    result_nz = any_nz || (!eff_sub && carry);
    neg_res   = flip ? !neg_a : neg_a;
  end

  always_comb begin
    alu_lowest = lowest;
    alu_cin    = carry;
    if (st == ST_RECOMP) begin
      alu_x   = 8'h00;
      alu_y   = a_byte;
      alu_sub = 1'b1;
    end else begin
      alu_x   = in_a ? a_byte : 8'h00;
      alu_y   = in_b ? b_byte : 8'h00;
      alu_sub = eff_sub;
    end
  end

  assign eng_idx   = idx;
  assign wr_en     = (st == ST_SUM) || (st == ST_RECOMP);
  assign wr_byte   = alu_r;
  assign sign_we   = st == ST_SIGN;
  assign sign_code = (result_nz && neg_res) ? SGN_MINUS : SGN_PLUS;
  assign busy      = st != ST_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx      <= '0;
      last_idx <= '0;
      lena_q   <= '0;
      lenb_q   <= '0;
      sub_q    <= 1'b0;
      mode_q   <= 1'b0;
      neg_a    <= 1'b0;
      neg_b    <= 1'b0;
      flip     <= 1'b0;
      carry    <= 1'b0;
      hi_nz    <= 1'b0;
      any_nz   <= 1'b0;
      done     <= 1'b0;
      data_exc <= 1'b0;
      dec_ovf  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          lena_q   <= len_a_m1;
          lenb_q   <= len_b_m1;
          last_idx <= (len_a_m1 > len_b_m1) ? len_a_m1 : len_b_m1;
          sub_q    <= sub_req;
          mode_q   <= alt_code_mode;
          idx      <= '0;
          data_exc <= 1'b0;
          dec_ovf  <= 1'b0;
          st       <= ST_CHECK;
        end
        ST_CHECK: begin
          if (lowest) begin
            neg_a <= code_is_minus(a_byte[3:0]);
            neg_b <= code_is_minus(b_byte[3:0]);
          end
          if (bad_byte) begin
            data_exc <= 1'b1;
            done     <= 1'b1;
            st       <= ST_IDLE;
          end else if (at_last) begin
            idx    <= '0;
            carry  <= 1'b0;
            hi_nz  <= 1'b0;
            any_nz <= 1'b0;
            flip   <= 1'b0;
            st     <= ST_SUM;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_SUM, ST_RECOMP: begin
          carry  <= alu_cout;
          any_nz <= any_nz | alu_nz;
          hi_nz  <= hi_nz | (alu_nz & beyond);
          if (!at_last) begin
            idx <= idx + 1'b1;
          end else if ((st == ST_SUM) && eff_sub && alu_cout) begin
            idx    <= '0;
            carry  <= 1'b0;
            any_nz <= 1'b0;
            hi_nz  <= 1'b0;
            flip   <= 1'b1;
            st     <= ST_RECOMP;
          end else begin
            st <= ST_SIGN;
          end
        end
        ST_SIGN: begin
          dec_ovf <= hi_nz || (!eff_sub && carry);
          done    <= 1'b1;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6
  exc_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && data_exc |-> !dec_ovf);
  // R4
  sign_alt_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sign_we && mode_q |-> (sign_code == 4'hC) || (sign_code == 4'hD));
  // R4
  sign_std_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sign_we && !mode_q |-> (sign_code == 4'hC) || (sign_code == 4'hD));
  // R5
  sum_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (alu_r[7:4] <= 4'd9) && (lowest || (alu_r[3:0] <= 4'd9)));
  // R10
  ign_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(lena_q) && $stable(lenb_q) && $stable(sub_q));

endmodule

// File: rtl/pdec_addsub_top.sv
module pdec_addsub_top #(
  parameter int MAX_BYTES = 16,
  localparam int AW = $clog2(MAX_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic          ld_sel,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data,
  input  logic [AW-1:0] len_a_m1,
  input  logic [AW-1:0] len_b_m1,
  input  logic          sub_req,
  input  logic          alt_code_mode,
  input  logic          start,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy,
  output logic          done,
  output logic          data_exc,
  output logic          dec_ovf
);
  logic [AW-1:0] eng_idx;
  logic [7:0]    a_byte, b_byte, alu_x, alu_y, alu_r, wr_byte;
  logic          alu_lowest, alu_cin, alu_sub, alu_cout, alu_nz;
  logic          wr_en, sign_we;
  logic [3:0]    sign_code;

  pdec_opbufs #(.DEPTH(MAX_BYTES), .AW(AW)) u_bufs (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .eng_idx(eng_idx), .a_byte(a_byte), .b_byte(b_byte),
    .wr_en(wr_en), .wr_byte(wr_byte),
    .sign_we(sign_we), .sign_code(sign_code)
  );

  pdec_byte_alu u_alu (
    .x_byte(alu_x), .y_byte(alu_y), .lowest(alu_lowest),
    .cin(alu_cin), .subtract(alu_sub),
    .r_byte(alu_r), .cout(alu_cout), .r_nonzero(alu_nz)
  );

  pdec_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .len_a_m1(len_a_m1), .len_b_m1(len_b_m1),
    .sub_req(sub_req), .alt_code_mode(alt_code_mode),
    .a_byte(a_byte), .b_byte(b_byte),
    .alu_x(alu_x), .alu_y(alu_y), .alu_lowest(alu_lowest),
    .alu_cin(alu_cin), .alu_sub(alu_sub),
    .alu_r(alu_r), .alu_cout(alu_cout), .alu_nz(alu_nz),
    .eng_idx(eng_idx), .wr_en(wr_en), .wr_byte(wr_byte),
    .sign_we(sign_we), .sign_code(sign_code),
    .busy(busy), .done(done), .data_exc(data_exc), .dec_ovf(dec_ovf)
  );

endmodule

// File: tb/tb_pdec_addsub_top.sv
module tb_pdec_addsub_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_en = 1'b0, ld_sel = 1'b0;
  logic [3:0] ld_addr = '0, len_a_m1 = '0, len_b_m1 = '0, rd_addr = '0;
  logic [7:0] ld_data = '0, rd_data;
  logic       sub_req = 1'b0, alt_code_mode = 1'b0, start = 1'b0;
  logic       busy, done, data_exc, dec_ovf;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int served = 0;

  typedef struct {
    logic [127:0] res;
    int           la;
    bit           exc;
    bit           ovf;
    string        tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  pdec_addsub_top dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_addr(ld_addr), .ld_data(ld_data), .len_a_m1(len_a_m1),
    .len_b_m1(len_b_m1), .sub_req(sub_req), .alt_code_mode(alt_code_mode),
    .start(start), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .done(done), .data_exc(data_exc), .dec_ovf(dec_ovf)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // digit k of a field: k=0 is byte0 high nibble, odd k low nibble of byte (k+1)/2
  function automatic int digit_of(input logic [127:0] v, input int len, input int k);
    int bi;
    logic [7:0] b;
    bi = (k + 1) / 2;
    if (bi >= len) return 0;
    b = v[8*bi +: 8];
    return (k % 2 == 1) ? int'(b[3:0]) : int'(b[7:4]);
  endfunction

  function automatic bit field_ok(input logic [127:0] v, input int len);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = v[8*i +: 8];
      if (b[7:4] > 9) return 0;
      if (i == 0 && b[3:0] <= 9) return 0;
      if (i != 0 && b[3:0] > 9) return 0;
    end
    return 1;
  endfunction

  task automatic model(input logic [127:0] va, input int la, input logic [127:0] vb,
                       input int lb, input bit sb, output logic [127:0] res,
                       output bit exc, output bit ovf);
    int  da[32], db[32], r[32];
    bit  na, nb, a_ge, neg, nz;
    int  c;
    res = va;
    ovf = 0;
    exc = !field_ok(va, la) || !field_ok(vb, lb);
    if (exc) return;
    na = (va[3:0] == 4'hB) || (va[3:0] == 4'hD);
    nb = ((vb[3:0] == 4'hB) || (vb[3:0] == 4'hD)) ^ sb;
    for (int k = 0; k < 32; k++) begin
      da[k] = digit_of(va, la, k);
      db[k] = digit_of(vb, lb, k);
    end
    c = 0;
    if (na == nb) begin
      for (int k = 0; k < 32; k++) begin
        r[k] = da[k] + db[k] + c;
        c = r[k] / 10;
        r[k] = r[k] % 10;
      end
      neg = na;
    end else begin
      a_ge = 1;
      for (int k = 31; k >= 0; k--) begin
        if (da[k] != db[k]) begin
          a_ge = da[k] > db[k];
          break;
        end
      end
      for (int k = 0; k < 32; k++) begin
        r[k] = a_ge ? (da[k] - db[k] - c) : (db[k] - da[k] - c);
        c = (r[k] < 0) ? 1 : 0;
        if (r[k] < 0) r[k] += 10;
      end
      neg = a_ge ? na : nb;
    end
    nz = 0;
    for (int k = 0; k < 32; k++) begin
      if (r[k] != 0) nz = 1;
      if (r[k] != 0 && k >= 2*la - 1) ovf = 1;
    end
    if (!nz) neg = 0;
    res = '0;
    res[3:0] = neg ? 4'hD : 4'hC;
    for (int k = 0; k < 2*la - 1; k++) begin
      int bi;
      bi = (k + 1) / 2;
      if (k % 2 == 1) res[8*bi +: 4] = 4'(r[k]);
      else            res[8*bi + 4 +: 4] = 4'(r[k]);
    end
  endtask

  task automatic load_buf(input bit sel, input logic [127:0] v);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_sel = sel; ld_addr = 4'(i); ld_data = v[8*i +: 8];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // driver: push expectation, launch, wait for the monitor
  task automatic run_op(input logic [127:0] va, input int la, input logic [127:0] vb,
                        input int lb, input bit sb, input bit md, input string tag,
                        input bit restart);
    exp_t e;
    load_buf(1'b0, va);
    load_buf(1'b1, vb);
    model(va, la, vb, lb, sb, e.res, e.exc, e.ovf);
    e.la = la;
    e.tag = tag;
    sb_q.push_back(e);
    pushed++;
    @(negedge clk);
    len_a_m1 = 4'(la - 1); len_b_m1 = 4'(lb - 1);
    sub_req = sb; alt_code_mode = md; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      @(negedge clk);
      len_a_m1 = 4'd15; len_b_m1 = 4'd15; sub_req = !sb; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (served == pushed);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        exp_t e;
        logic [127:0] got;
        bit ok;
        if (sb_q.size() == 0) begin
          check(0, "R9 unexpected done", 1, 0);
        end else begin
          e = sb_q.pop_front();
          check(!busy, {e.tag, " R9 busy low at done"}, 128'(busy), 0);
          check(data_exc == e.exc, {e.tag, " R6 data_exc"}, 128'(data_exc), 128'(e.exc));
          check(dec_ovf == e.ovf, {e.tag, " R7 dec_ovf"}, 128'(dec_ovf), 128'(e.ovf));
          @(negedge clk);
          check(!done, {e.tag, " R9 single-cycle done"}, 128'(done), 0);
          check(data_exc == e.exc && dec_ovf == e.ovf, {e.tag, " R9 flags held"},
                {126'b0, data_exc, dec_ovf}, {126'b0, e.exc, e.ovf});
          got = '0;
          ok = 1;
          for (int i = 0; i < e.la; i++) begin
            rd_addr = 4'(i);
            #1;
            got[8*i +: 8] = rd_data;
            if (rd_data !== e.res[8*i +: 8]) ok = 0;
          end
          check(ok, {e.tag, " R2 result bytes"}, got, e.res);
        end
        served++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!done && !busy && !data_exc && !dec_ovf, "R1 reset state",
          {124'b0, done, busy, data_exc, dec_ovf}, 0);

    run_op(128'h123C, 2, 128'h45C, 2, 0, 0, "R5 add +123 +45", 0);
    run_op(128'h123C, 2, 128'h45C, 2, 1, 0, "R5 sub +123 -45", 0);
    run_op(128'h3C, 1, 128'h8C, 1, 1, 0, "R11 3-8", 0);
    run_op(128'h00100C, 3, 128'h999D, 2, 0, 0, "R11 complement across lengths", 0);
    run_op(128'h5D, 1, 128'h5C, 1, 0, 0, "R8 -5+5 zero", 0);
    run_op(128'h0D, 1, 128'h0B, 1, 0, 0, "R8 -0 plus -0", 0);
    run_op(128'h7A, 1, 128'h2B, 1, 0, 0, "R3 codes A and B", 0);
    run_op(128'h1F, 1, 128'h1E, 1, 1, 0, "R3 codes F and E", 0);
    run_op(128'h4D, 1, 128'h3D, 1, 0, 0, "R3 code D add", 0);
    run_op(128'h4D, 1, 128'h3D, 1, 0, 1, "R4 alt mode minus", 0);
    run_op(128'h4C, 1, 128'h3C, 1, 0, 1, "R4 alt mode plus", 0);
    run_op(128'h2C, 1, 128'h00001C, 3, 0, 0, "R5 short op1 long op2", 0);
    run_op(128'h00100C, 3, 128'h2C, 1, 1, 0, "R5 long op1 short op2", 0);
    run_op(128'h2C, 1, 128'h00100C, 3, 0, 0, "R7 overflow from long op2", 0);
    run_op(128'h9C, 1, 128'h1C, 1, 0, 0, "R7 carry overflow", 0);
    run_op(128'h5D, 1, 128'h5D, 1, 0, 0, "R7 overflow keeps minus", 0);
    run_op(128'h0A3C, 2, 128'h1C, 1, 0, 0, "R6 bad digit op1", 0);
    run_op(128'h3C, 1, 128'h55, 1, 0, 0, "R6 bad sign op2", 0);
    run_op(128'h3C, 1, 128'h1C, 1, 0, 0, "R10 restart ignored", 1);

    for (int n = 0; n < 150; n++) begin
      logic [127:0] va, vb;
      logic [3:0] codes [6];
      int la, lb;
      codes = '{4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF};
      la = $urandom_range(1, 16);
      lb = $urandom_range(1, 16);
      va = '0;
      vb = '0;
      for (int i = 0; i < 16; i++) begin
        va[8*i +: 8] = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
        vb[8*i +: 8] = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
      end
      va[3:0] = codes[$urandom_range(0, 5)];
      vb[3:0] = codes[$urandom_range(0, 5)];
      if ($urandom_range(0, 7) == 0) begin
        vb = va;
        lb = la;
      end
      if ($urandom_range(0, 15) == 0) va[8*$urandom_range(0, la - 1) + 4 +: 4] = 4'hB;
      run_op(va, la, vb, lb, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             "R5 random", 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule